// File: doc/BRIEF.md
# Destination Software Handshake Request Register

This block is one channel's control register for destination-side software handshaking in a DMA controller. When a channel's destination has no hardware request line, software writes this register to post a transfer request: a plain burst request, a single-beat request, or a last request that closes the transfer. Each request bit has a write-enable partner that must be set in the same write. This lets software set one request without a read-modify-write. Software can only set request bits. All pending request bits are cleared by hardware once the channel's acknowledge logic reports that software has read the acknowledge flag as set.

The register state is decoded into four mutually exclusive request strobes for the channel engine: burst, single, last-burst and last-single. The decode depends on whether software handshaking is enabled and whether the destination controls the flow. The strobes hold for as long as the request stays pending. A parameter selects whether the strobes come straight from the register bits or pass through one more register stage.

Top module: `dma_swhs_dst_req`

## Requirements
- R1: After reset all three request bits are 0, every request strobe is 0 and a read of the register returns 0.
- R2: Field layout: request at bit 0 with its write enable at bit 1, single at bit 2 with its enable at bit 3, last at bit 4 with its enable at bit 5. A write to the register address sets a request bit only when that bit and its enable bit are both 1 in the same write. A field whose enable is 0 keeps its value.
- R3: While `chan_en` is 0, writes leave all request bits unchanged.
- R4: Writing 0 to a request bit with its enable set has no effect. Only the hardware clear lowers a request bit.
- R5: A read at the register address returns the request bits at bits 0, 2 and 4. The enable bits and bits DATA_W-1:6 always read as 0, and writes to the reserved bits change nothing. A read at any other address returns 0.
- R6: A cycle with `ack_seen` high clears all three request bits at that clock edge. When a qualifying write occurs in the same cycle, the clear takes priority and the bits end at 0.
- R7: With `swhs_en`=1, `dst_flow_ctl`=1, request=1 and last=1, the block raises `req_last_single` if single=1, otherwise `req_last_burst`.
- R8: The last bit is ignored when request=0 or `dst_flow_ctl`=0. The decode then falls back to the R10 rules, and the last bit stays held in the register.
- R9: While `swhs_en`=0 all four strobes are 0, whatever the register holds.
- R10: When R7 does not apply and `swhs_en`=1: single=1 gives `req_single`, else request=1 gives `req_burst`, else no strobe. At most one strobe is ever high, and a strobe holds until the bits are cleared.
- R11: Writes to any address other than REG_ADDR leave the request bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data (combinational, 0 when not selected) |
| chan_en | input | 1 | Channel enabled; gates writes |
| swhs_en | input | 1 | Destination uses software handshaking |
| dst_flow_ctl | input | 1 | Destination is the flow controller |
| ack_seen | input | 1 | Acknowledge flag was read as set; clears requests |
| req_burst | output | 1 | Burst request strobe |
| req_single | output | 1 | Single-beat request strobe |
| req_last_burst | output | 1 | Last burst request strobe |
| req_last_single | output | 1 | Last single-beat request strobe |

## Verification
The assertions check several rules on every cycle. The strobes stay one-hot or idle. A set bit never falls except on an acknowledge. The acknowledge always leaves the register empty. Writes on a disabled channel change nothing. Readback matches the held bits, with enables and reserved bits at zero. Some behaviour only the bench's scenarios can show: the exact decode of last/single/burst under each combination of handshaking and flow-control inputs, the need for a matching enable bit, the rejection of other addresses, and the clear-over-set priority under a colliding write. A behavioural model checks these on every clock.

// File: rtl/dma_swhs_pkg.sv
package dma_swhs_pkg;

   localparam int unsigned FLD_REQ = 0;
   localparam int unsigned FLD_SGL = 1;
   localparam int unsigned FLD_LST = 2;
   localparam int unsigned NUM_FLD = 3;
   localparam int unsigned USED_W  = 2 * NUM_FLD;

   // each field: value at even bit, its write enable right above it
   function automatic int unsigned val_bit(input int unsigned fld);
      return 2 * fld;
   endfunction

   function automatic int unsigned we_bit(input int unsigned fld);
      return 2 * fld + 1;
   endfunction

   typedef enum logic [1:0] {
      KIND_BURST       = 2'd0,
      KIND_SINGLE      = 2'd1,
      KIND_LAST_BURST  = 2'd2,
      KIND_LAST_SINGLE = 2'd3
   } req_kind_e;

   localparam int unsigned NUM_KIND = 4;

endpackage

// File: rtl/swhs_sticky_bit.sv
module swhs_sticky_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q_o <= 1'b0;
      else if (clr_i) q_o <= 1'b0;
      else if (set_i) q_o <= 1'b1;
   end

   p_clear_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> !q_o);

   p_set_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (q_o && !clr_i) |=> q_o);

   p_idle_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_i && !clr_i) |=> $stable(q_o));

endmodule

// File: rtl/swhs_req_decode.sv
module swhs_req_decode
   import dma_swhs_pkg::*;
#(
   parameter bit OUT_REG = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_FLD-1:0]  bits_i,
   input  logic                swhs_en_i,
   input  logic                dst_fc_i,
   output logic [NUM_KIND-1:0] kind_o
);

   logic [NUM_KIND-1:0] kind_c;
   logic                last_ok;

   always_comb begin
      kind_c  = '0;
      last_ok = bits_i[FLD_REQ] && bits_i[FLD_LST] && dst_fc_i;
      if (swhs_en_i) begin
         if (last_ok) begin
            if (bits_i[FLD_SGL]) kind_c[KIND_LAST_SINGLE] = 1'b1;
            else                 kind_c[KIND_LAST_BURST]  = 1'b1;
         end else if (bits_i[FLD_SGL]) begin
            kind_c[KIND_SINGLE] = 1'b1;
         end else if (bits_i[FLD_REQ]) begin
            kind_c[KIND_BURST] = 1'b1;
         end
      end
   end

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) kind_o <= '0;
            else        kind_o <= kind_c;
         end
         p_gated_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !swhs_en_i |=> (kind_o == '0));
      end else begin : g_comb
         assign kind_o = kind_c;
         p_gated_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !swhs_en_i |-> (kind_o == '0));
      end
   endgenerate

   p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(kind_o));

endmodule

// File: rtl/swhs_rd_mux.sv
module swhs_rd_mux
   import dma_swhs_pkg::*;
#(
   parameter int unsigned DATA_W = 64
) (
   input  logic               sel_i,
   input  logic [NUM_FLD-1:0] bits_i,
   output logic [DATA_W-1:0]  rdata_o
);

   always_comb begin
      rdata_o = '0;
      if (sel_i) begin
         for (int f = 0; f < NUM_FLD; f++) begin
            rdata_o[val_bit(f)] = bits_i[f];
         end
      end
   end

endmodule

// File: rtl/dma_swhs_dst_req.sv
module dma_swhs_dst_req
   import dma_swhs_pkg::*;
#(
   parameter int unsigned DATA_W   = 64,
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned REG_ADDR = 'h40,
   parameter bit          OUT_REG  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              chan_en,
   input  logic              swhs_en,
   input  logic              dst_flow_ctl,
   input  logic              ack_seen,
   output logic              req_burst,
   output logic              req_single,
   output logic              req_last_burst,
   output logic              req_last_single
);

   localparam logic [ADDR_W-1:0] ADDR_HIT = ADDR_W'(REG_ADDR);

   generate
      if (DATA_W < USED_W) begin : g_bad_width
         $error("dma_swhs_dst_req: DATA_W too small for the field layout");
      end
      if (ADDR_W < 1 || ADDR_W > 31) begin : g_bad_addr_w
         $error("dma_swhs_dst_req: ADDR_W out of range");
      end else if (REG_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
         $error("dma_swhs_dst_req: REG_ADDR does not fit in ADDR_W");
      end
   endgenerate

   logic               addr_hit;
   logic               wr_ok;
   logic               rd_sel;
   logic [NUM_FLD-1:0] held;
   logic [NUM_FLD-1:0] set_fld;
   logic [NUM_KIND-1:0] kind;
   logic               unused_wdata;

   assign addr_hit = (reg_addr == ADDR_HIT);
   assign wr_ok    = reg_wr && addr_hit && chan_en;
   assign rd_sel   = reg_rd && addr_hit;

   generate
      if (DATA_W > USED_W) begin : g_rsvd
         assign unused_wdata = ^reg_wdata[DATA_W-1:USED_W];
      end else begin : g_norsvd
         assign unused_wdata = 1'b0;
      end

      for (genvar f = 0; f < NUM_FLD; f++) begin : g_fld
         localparam int unsigned VB = val_bit(f);
         localparam int unsigned WB = we_bit(f);
         assign set_fld[f] = wr_ok && reg_wdata[WB] && reg_wdata[VB];
         swhs_sticky_bit i_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (set_fld[f]),
            .clr_i (ack_seen),
            .q_o   (held[f])
         );
      end
   endgenerate

   swhs_req_decode #(.OUT_REG(OUT_REG)) i_decode (
      .clk       (clk),
      .rst_n     (rst_n),
      .bits_i    (held),
      .swhs_en_i (swhs_en),
      .dst_fc_i  (dst_flow_ctl),
      .kind_o    (kind)
   );

   swhs_rd_mux #(.DATA_W(DATA_W)) i_rdmux (
      .sel_i   (rd_sel),
      .bits_i  (held),
      .rdata_o (reg_rdata)
   );

   assign req_burst       = kind[KIND_BURST];
   assign req_single      = kind[KIND_SINGLE];
   assign req_last_burst  = kind[KIND_LAST_BURST];
   assign req_last_single = kind[KIND_LAST_SINGLE];

   p_disabled_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!chan_en && !ack_seen) |=> $stable(held));

   p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ack_seen |=> (held == '0));

   p_readback_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_sel |-> (reg_rdata[0] == held[FLD_REQ] && reg_rdata[2] == held[FLD_SGL]
                  && reg_rdata[4] == held[FLD_LST]
                  && $countones(reg_rdata) == $countones(held)));

   p_other_addr_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!addr_hit && !ack_seen) |=> $stable(held));

endmodule

// File: tb/test_dma_swhs_dst_req.sv
module test_dma_swhs_dst_req;

   localparam int DW = 64;
   localparam int AW = 8;
   localparam logic [AW-1:0] RA = 8'h40;

   logic          clk = 0;
   logic          rst_n = 0;
   logic          reg_wr = 0, reg_rd = 0;
   logic [AW-1:0] reg_addr = RA;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic          chan_en = 0, swhs_en = 0, dst_flow_ctl = 0, ack_seen = 0;
   logic          req_burst, req_single, req_last_burst, req_last_single;

   int    errors = 0;
   int    checks = 0;
   string tag = "R1";
   bit    done = 0;

   // reference model state
   int m_req = 0, m_sgl = 0, m_lst = 0;

   always #10 clk = ~clk;

   dma_swhs_dst_req i_dma_swhs_dst_req (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .chan_en(chan_en), .swhs_en(swhs_en), .dst_flow_ctl(dst_flow_ctl),
      .ack_seen(ack_seen), .req_burst(req_burst), .req_single(req_single),
      .req_last_burst(req_last_burst), .req_last_single(req_last_single)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [3:0] exp_kind();
      logic [3:0] k = 4'b0; // {last_single,last_burst,single,burst}
      if (swhs_en) begin
         if (m_req && m_lst && dst_flow_ctl) k = m_sgl ? 4'b1000 : 4'b0100;
         else if (m_sgl) k = 4'b0010;
         else if (m_req) k = 4'b0001;
      end
      return k;
   endfunction

   function automatic logic [DW-1:0] exp_rd();
      if (reg_rd && reg_addr == RA) return DW'(m_req + 4 * m_sgl + 16 * m_lst);
      return '0;
   endfunction

   // model update and per-clock comparison
   always @(posedge clk) begin
      if (!rst_n) begin
         m_req = 0; m_sgl = 0; m_lst = 0;
      end else if (ack_seen) begin
         m_req = 0; m_sgl = 0; m_lst = 0;
      end else if (reg_wr && reg_addr == RA && chan_en) begin
         if (reg_wdata[1] && reg_wdata[0]) m_req = 1;
         if (reg_wdata[3] && reg_wdata[2]) m_sgl = 1;
         if (reg_wdata[5] && reg_wdata[4]) m_lst = 1;
      end
      #5;
      if (rst_n && !done) begin
         logic [3:0] act;
         act = {req_last_single, req_last_burst, req_single, req_burst};
         check(act == exp_kind(), tag, "strobes", act, exp_kind());
         check(reg_rdata == exp_rd(), tag, "rdata", reg_rdata, exp_rd());
      end
   end

   task automatic step(input bit wr, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input bit rd, input bit ack);
      reg_wr = wr; reg_addr = a; reg_wdata = d; reg_rd = rd; ack_seen = ack;
      @(negedge clk);
      reg_wr = 0; reg_rd = 0; ack_seen = 0;
   endtask

   task automatic rd_check(input string req, input logic [DW-1:0] exp);
      reg_rd = 1; reg_addr = RA; #1;
      check(reg_rdata == exp, req, "readback", reg_rdata, exp);
      reg_rd = 0;
   endtask

   task automatic strobe_check(input string req, input logic [3:0] exp);
      logic [3:0] act;
      act = {req_last_single, req_last_burst, req_single, req_burst};
      check(act == exp, req, "strobe vector", act, exp);
   endtask

   initial begin
      #3_000_000;
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [15:0] lf;
      @(negedge clk); @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      tag = "R1";
      strobe_check("R1", 4'b0000);
      rd_check("R1", 64'h0);

      tag = "R3"; swhs_en = 1; chan_en = 0;
      step(1, RA, 64'h3F, 0, 0);
      rd_check("R3", 64'h0);
      strobe_check("R3", 4'b0000);

      tag = "R2"; chan_en = 1;
      step(1, RA, 64'h15, 0, 0);           // values without enables
      rd_check("R2", 64'h0);

      tag = "R10";
      step(1, RA, 64'h03, 0, 0);
      strobe_check("R10", 4'b0001);
      step(1, RA, 64'h0C, 0, 0);
      strobe_check("R10", 4'b0010);
      step(0, RA, 64'h0, 0, 0);
      strobe_check("R10", 4'b0010);        // holds

      tag = "R7"; dst_flow_ctl = 1;
      step(1, RA, 64'h30, 0, 0);
      strobe_check("R7", 4'b1000);
      tag = "R5";
      step(0, RA, 64'h0, 1, 0);
      rd_check("R5", 64'h15);

      tag = "R4";
      step(1, RA, 64'h2A, 0, 0);           // enables with zero values
      rd_check("R4", 64'h15);

      tag = "R6";
      step(0, RA, 64'h0, 0, 1);
      rd_check("R6", 64'h0);
      strobe_check("R6", 4'b0000);

      tag = "R7";
      step(1, RA, 64'h33, 0, 0);
      strobe_check("R7", 4'b0100);
      tag = "R8"; dst_flow_ctl = 0;
      step(0, RA, 64'h0, 0, 0);
      strobe_check("R8", 4'b0001);
      tag = "R9"; swhs_en = 0;
      step(0, RA, 64'h0, 0, 0);
      strobe_check("R9", 4'b0000);
      rd_check("R9", 64'h11);
      swhs_en = 1;

      tag = "R6";
      step(1, RA, 64'h3F, 0, 1);           // clear collides with set
      rd_check("R6", 64'h0);

      tag = "R8"; dst_flow_ctl = 1;
      step(1, RA, 64'h30, 0, 0);
      strobe_check("R8", 4'b0000);
      rd_check("R8", 64'h10);
      step(0, RA, 64'h0, 0, 1);

      tag = "R11";
      step(1, 8'h44, 64'h3F, 0, 0);
      rd_check("R11", 64'h0);
      step(1, RA, 64'h3F, 1, 0);
      reg_addr = 8'h48; reg_rd = 1; #1;
      check(reg_rdata == 64'h0, "R11", "other-address read", reg_rdata, 0);
      reg_rd = 0; reg_addr = RA;
      step(0, RA, 64'h0, 0, 1);

      tag = "R5";
      step(1, RA, 64'hFFFF_FFFF_FFFF_FFC0, 0, 0);
      rd_check("R5", 64'h0);

      // pseudo-random traffic against the model
      tag = "R10";
      lf = 16'hACE1;
      for (int i = 0; i < 400; i++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         chan_en      = lf[0] | lf[7];
         swhs_en      = lf[1] | lf[9];
         dst_flow_ctl = lf[2];
         step(lf[3], lf[11] ? 8'h44 : RA, {58'h0, lf[15:10]}, lf[4],
              (lf[5] & lf[6] & lf[8]));
      end

      @(negedge clk);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule